// File: doc/BRIEF.md
# Dual-Bank Indexed NVRAM Port

This block gives a host access to a 256-location byte space through two independent index/data port pairs, in the manner of the battery-backed configuration memory found in PC chipsets. The lower pair reaches locations 0 to 127 and the upper pair reaches 128 to 255. Software first writes an index byte to a pair's index port and then reads or writes that pair's data port. The index stays latched, so any number of data accesses can follow without rewriting it.

Locations 0 to 13 hold the time-keeping registers, which live outside this block. Data-port accesses to them are passed to an external register strobe interface. Up to three more locations, chosen by parameters (day alarm, month alarm, century), are passed out in the same way. Every other implemented location is plain byte storage inside the block. The implemented size is set by a parameter to 64, 128 or 256 bytes. Locations beyond that size read as 0xFF and ignore writes, so with 64 or 128 bytes the whole upper bank is empty.

Top module: `nvram_bank_port`

## Requirements
- R1: A write to port 0 (lower index) latches bits 6:0 of the write data and ignores bit 7. A read of port 0 returns {0, latched lower index}.
- R2: A write to port 2 (upper index) latches bits 6:0. A read of port 2 returns {1, latched upper index}, which is the location 128 plus that index.
- R3: A data access on port 1 targets location {0, lower index}. A byte written to a storage location there is returned by later reads of that location.
- R4: A data access on port 3 targets location {1, upper index}. The two pairs keep separate indices, and writing one index leaves the other unchanged.
- R5: A data access to a location in 0 to 13 goes to the register interface. The access drives creg_addr with the location. A write drives creg_wdata with the data and raises creg_we for that cycle only. A read raises creg_re, and host_rdata returns creg_rdata in the same cycle.
- R6: The locations named by DAY_LOC, MON_LOC and CEN_LOC are handled exactly as in R5, provided each is nonzero, at least 14 and below MEM_BYTES. A parameter value of 0 disables that location.
- R7: A location at or above MEM_BYTES reads as 0xFF on its data port. Writes to it change nothing and raise no strobe.
- R8: Data accesses do not change either index. Repeated data accesses hit the same location.
- R9: After reset, the lower index is 0 and the upper index is 0, so ports 0 and 2 read 0x00 and 0x80.
- R10: host_rdata is 0x00 whenever host_rd is low. creg_we and creg_re stay low except during a data-port access to a register-routed location.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_sel | input | 2 | Port select: 0 lower index, 1 lower data, 2 upper index, 3 upper data |
| host_wr | input | 1 | Write strobe, one cycle per write |
| host_rd | input | 1 | Read strobe; data is returned combinationally in the same cycle |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data, 0 when host_rd is low |
| creg_addr | output | 8 | Location of the current register-routed access |
| creg_wdata | output | 8 | Write data for the register interface |
| creg_we | output | 1 | Register write strobe |
| creg_re | output | 1 | Register read strobe |
| creg_rdata | input | 8 | Read data from the external registers, same cycle |

## Verification
The assertions assume the host never raises host_rd and host_wr in the same cycle. They also assume creg_rdata is a function of creg_addr that is valid within the cycle. The stimulus drives exactly one of the two strobes per operation, or neither. It feeds creg_rdata from a fixed combinational function of the address, and changes inputs only at the falling edge. Storage reads are compared only for locations already written, because the array has no reset. Two instances, one with 256 bytes and one with 64 bytes, share the host bus, so the same index and data traffic exercises both the routed locations and the empty ones.

// File: rtl/nvram_bank_pkg.sv
`timescale 1ns/1ps
package nvram_bank_pkg;

    typedef enum logic [1:0] {
        PORT_LO_IDX = 2'd0,
        PORT_LO_DAT = 2'd1,
        PORT_HI_IDX = 2'd2,
        PORT_HI_DAT = 2'd3
    } port_e;

    typedef enum logic [1:0] {
        AK_RAM   = 2'd0,
        AK_CLOCK = 2'd1,
        AK_VOID  = 2'd2
    } acc_kind_e;

    localparam int IDX_W = 7;

    typedef struct packed {
        logic [IDX_W-1:0] lo;
        logic [IDX_W-1:0] hi;
    } idx_state_t;

endpackage

// File: rtl/nvram_bank_index.sv
`timescale 1ns/1ps
module nvram_bank_index
    import nvram_bank_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       sel,
    input  logic             wr,
    input  logic [7:0]       wdata,
    output logic [IDX_W-1:0] lo_idx,
    output logic [IDX_W-1:0] hi_idx
);

    idx_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr && port_e'(sel) == PORT_LO_IDX) begin
            st_d.lo = wdata[IDX_W-1:0];
        end
        if (wr && port_e'(sel) == PORT_HI_IDX) begin
            st_d.hi = wdata[IDX_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign lo_idx = st_q.lo;
    assign hi_idx = st_q.hi;

endmodule

// File: rtl/nvram_bank_decode.sv
`timescale 1ns/1ps
module nvram_bank_decode
    import nvram_bank_pkg::*;
#(
    parameter int MEM_BYTES = 256,
    parameter int CLK_REGS  = 14,
    parameter int DAY_LOC   = 125,
    parameter int MON_LOC   = 126,
    parameter int CEN_LOC   = 50
) (
    input  logic [7:0] addr,
    output acc_kind_e  kind
);

    localparam int N_EXTRA = 3;
    localparam int EXTRA_LOC [N_EXTRA] = '{DAY_LOC, MON_LOC, CEN_LOC};

    logic [N_EXTRA-1:0] extra_hit;

    for (genvar g = 0; g < N_EXTRA; g++) begin : g_extra
        if (EXTRA_LOC[g] >= CLK_REGS && EXTRA_LOC[g] < MEM_BYTES) begin : g_on
            assign extra_hit[g] = (addr == 8'(EXTRA_LOC[g]));
        end else begin : g_off
            assign extra_hit[g] = 1'b0;
        end
    end

    always_comb begin
        if (int'(addr) < CLK_REGS || |extra_hit) begin
            kind = AK_CLOCK;
        end else if (int'(addr) >= MEM_BYTES) begin
            kind = AK_VOID;
        end else begin
            kind = AK_RAM;
        end
    end

endmodule

// File: rtl/nvram_bank_store.sv
`timescale 1ns/1ps
module nvram_bank_store #(
    parameter int DEPTH = 256,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [7:0]    wdata,
    output logic [7:0]    rdata
);

    logic [7:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[addr] <= wdata;
        end
    end

    assign rdata = mem_q[addr];

endmodule

// File: rtl/nvram_bank_port.sv
`timescale 1ns/1ps
module nvram_bank_port
    import nvram_bank_pkg::*;
#(
    parameter int MEM_BYTES = 256,
    parameter int CLK_REGS  = 14,
    parameter int DAY_LOC   = 125,
    parameter int MON_LOC   = 126,
    parameter int CEN_LOC   = 50
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] host_sel,
    input  logic       host_wr,
    input  logic       host_rd,
    input  logic [7:0] host_wdata,
    output logic [7:0] host_rdata,
    output logic [7:0] creg_addr,
    output logic [7:0] creg_wdata,
    output logic       creg_we,
    output logic       creg_re,
    input  logic [7:0] creg_rdata
);

    localparam int AW = $clog2(MEM_BYTES);

    logic [IDX_W-1:0] lo_idx, hi_idx;
    logic [7:0]       acc_addr;
    logic             is_data;
    acc_kind_e        kind;
    logic [7:0]       store_rdata;
    logic             store_we;

    nvram_bank_index u_index (
        .clk    (clk),
        .rst_n  (rst_n),
        .sel    (host_sel),
        .wr     (host_wr),
        .wdata  (host_wdata),
        .lo_idx (lo_idx),
        .hi_idx (hi_idx)
    );

    assign is_data  = host_sel[0];
    assign acc_addr = host_sel[1] ? {1'b1, hi_idx} : {1'b0, lo_idx};

    nvram_bank_decode #(
        .MEM_BYTES (MEM_BYTES),
        .CLK_REGS  (CLK_REGS),
        .DAY_LOC   (DAY_LOC),
        .MON_LOC   (MON_LOC),
        .CEN_LOC   (CEN_LOC)
    ) u_decode (
        .addr (acc_addr),
        .kind (kind)
    );

    assign store_we = host_wr && is_data && kind == AK_RAM;

    nvram_bank_store #(.DEPTH(MEM_BYTES)) u_store (
        .clk   (clk),
        .we    (store_we),
        .addr  (acc_addr[AW-1:0]),
        .wdata (host_wdata),
        .rdata (store_rdata)
    );

    always_comb begin
        creg_addr  = acc_addr;
        creg_wdata = host_wdata;
        creg_we    = host_wr && is_data && kind == AK_CLOCK;
        creg_re    = host_rd && is_data && kind == AK_CLOCK;
        host_rdata = 8'h00;
        if (host_rd) begin
            unique case (port_e'(host_sel))
                PORT_LO_IDX: host_rdata = {1'b0, lo_idx};
                PORT_HI_IDX: host_rdata = {1'b1, hi_idx};
                default: begin
                    unique case (kind)
                        AK_CLOCK: host_rdata = creg_rdata;
                        AK_RAM:   host_rdata = store_rdata;
                        default:  host_rdata = 8'hFF;
                    endcase
                end
            endcase
        end
    end

endmodule

// File: rtl/nvram_bank_port_chk.sv
`timescale 1ns/1ps
module nvram_bank_port_chk #(
    parameter int MEM_BYTES = 256,
    parameter int CLK_REGS  = 14
) (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] host_sel,
    input logic       host_wr,
    input logic       host_rd,
    input logic [7:0] host_wdata,
    input logic [7:0] host_rdata,
    input logic [7:0] creg_addr,
    input logic [7:0] creg_wdata,
    input logic       creg_we,
    input logic       creg_re,
    input logic [6:0] lo_idx,
    input logic [6:0] hi_idx
);

    logic [7:0] addr_c;
    assign addr_c = host_sel[1] ? {1'b1, hi_idx} : {1'b0, lo_idx};

    AST_LO_IDX_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_sel == 2'd0) |=> lo_idx == $past(host_wdata[6:0])); // R1

    AST_HI_IDX_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_sel == 2'd2) |=> hi_idx == $past(host_wdata[6:0])); // R2

    AST_IDX_HOLD_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        host_sel[0] |=> (lo_idx == $past(lo_idx) && hi_idx == $past(hi_idx))); // R8

    AST_FWD_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        creg_we |-> (host_wr && host_sel[0] && creg_wdata == host_wdata)); // R5

    AST_FWD_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (creg_we || creg_re) |-> creg_addr == addr_c); // R5

    AST_LOW_REGS_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && host_sel[0] && int'(addr_c) < CLK_REGS) |-> creg_re); // R5

    AST_VOID_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && host_sel[0] && int'(addr_c) >= MEM_BYTES) |-> host_rdata == 8'hFF); // R7

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !host_rd |-> (host_rdata == 8'h00 && !creg_re)); // R10

endmodule

bind nvram_bank_port nvram_bank_port_chk #(
    .MEM_BYTES (MEM_BYTES),
    .CLK_REGS  (CLK_REGS)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_sel   (host_sel),
    .host_wr    (host_wr),
    .host_rd    (host_rd),
    .host_wdata (host_wdata),
    .host_rdata (host_rdata),
    .creg_addr  (creg_addr),
    .creg_wdata (creg_wdata),
    .creg_we    (creg_we),
    .creg_re    (creg_re),
    .lo_idx     (lo_idx),
    .hi_idx     (hi_idx)
);

// File: tb/nvram_bank_port_test.sv
`timescale 1ns/1ps
module nvram_bank_port_test;

    localparam int B_SIZE = 256, B_DAY = 125, B_MON = 126, B_CEN = 50;
    localparam int S_SIZE = 64,  S_DAY = 48,  S_MON = 0,   S_CEN = 0;
    localparam int KR = 0, KC = 1, KV = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] host_sel = 2'd0;
    logic       host_wr = 1'b0, host_rd = 1'b0;
    logic [7:0] host_wdata = 8'h00;
    logic [7:0] b_rdata, b_caddr, b_cwdata, b_crdata;
    logic       b_cwe, b_cre;
    logic [7:0] s_rdata, s_caddr, s_cwdata, s_crdata;
    logic       s_cwe, s_cre;

    int n_cmp = 0, n_bad = 0;
    bit done = 0;

    logic [6:0] lo_m = '0, hi_m = '0;
    logic [7:0] mem_b [256];
    logic [7:0] mem_s [256];
    bit         val_b [256];
    bit         val_s [256];

    always #2.5 clk = ~clk;

    assign b_crdata = b_caddr ^ 8'hA5;
    assign s_crdata = s_caddr ^ 8'hA5;

    nvram_bank_port #(.MEM_BYTES(B_SIZE), .DAY_LOC(B_DAY), .MON_LOC(B_MON), .CEN_LOC(B_CEN)) uut (
        .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_wr(host_wr), .host_rd(host_rd),
        .host_wdata(host_wdata), .host_rdata(b_rdata), .creg_addr(b_caddr), .creg_wdata(b_cwdata),
        .creg_we(b_cwe), .creg_re(b_cre), .creg_rdata(b_crdata));

    nvram_bank_port #(.MEM_BYTES(S_SIZE), .DAY_LOC(S_DAY), .MON_LOC(S_MON), .CEN_LOC(S_CEN)) uut_small (
        .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_wr(host_wr), .host_rd(host_rd),
        .host_wdata(host_wdata), .host_rdata(s_rdata), .creg_addr(s_caddr), .creg_wdata(s_cwdata),
        .creg_we(s_cwe), .creg_re(s_cre), .creg_rdata(s_crdata));

    function automatic int cls(input logic [7:0] a, input int size, input int d, input int m, input int c);
        int ai = int'(a);
        if (ai < 14) return KC;
        if ((d >= 14 && d < size && ai == d) || (m >= 14 && m < size && ai == m) ||
            (c >= 14 && c < size && ai == c)) return KC;
        if (ai >= size) return KV;
        return KR;
    endfunction

    function automatic string tag_of(input logic [1:0] s, input int k);
        if (s == 2'd0) return "R1";
        if (s == 2'd2) return "R2";
        if (k == KC) return "R5/R6";
        if (k == KV) return "R7";
        return (s == 2'd1) ? "R3" : "R4";
    endfunction

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic op(input logic [1:0] s, input logic w, input logic r, input logic [7:0] d);
        logic [7:0] a;
        int kb, ks;
        @(negedge clk);
        host_sel = s; host_wr = w; host_rd = r; host_wdata = d;
        #1;
        a  = s[1] ? {1'b1, hi_m} : {1'b0, lo_m};
        kb = cls(a, B_SIZE, B_DAY, B_MON, B_CEN);
        ks = cls(a, S_SIZE, S_DAY, S_MON, S_CEN);
        if (r) begin
            if (!s[0]) begin
                chk(tag_of(s, kb), b_rdata, {s[1], s[1] ? hi_m : lo_m});
            end else begin
                if (kb == KC) chk(tag_of(s, kb), b_rdata, a ^ 8'hA5);
                else if (kb == KV) chk(tag_of(s, kb), b_rdata, 8'hFF);
                else if (val_b[a]) chk(tag_of(s, kb), b_rdata, mem_b[a]);
                if (ks == KC) chk(tag_of(s, ks), s_rdata, a ^ 8'hA5);
                else if (ks == KV) chk(tag_of(s, ks), s_rdata, 8'hFF);
                else if (val_s[a]) chk(tag_of(s, ks), s_rdata, mem_s[a]);
            end
        end else begin
            chk("R10 idle rdata", b_rdata, 8'h00);
        end
        if (s[0]) begin
            chk("R5 we strobe", {7'd0, b_cwe}, {7'd0, w && kb == KC});
            chk("R5 re strobe", {7'd0, b_cre}, {7'd0, r && kb == KC});
            chk("R7 small we strobe", {7'd0, s_cwe}, {7'd0, w && ks == KC});
            if (kb == KC) begin
                chk("R5 addr", b_caddr, a);
                if (w) chk("R5 wdata", b_cwdata, d);
            end
        end else begin
            chk("R10 no strobe", {6'd0, b_cwe, b_cre}, 8'h00);
        end
        @(posedge clk);
        if (w) begin
            if (s == 2'd0) lo_m = d[6:0];
            else if (s == 2'd2) hi_m = d[6:0];
            else begin
                if (kb == KR) begin mem_b[a] = d; val_b[a] = 1; end
                if (ks == KR) begin mem_s[a] = d; val_s[a] = 1; end
            end
        end
    endtask

    task automatic idle();
        @(negedge clk);
        host_wr = 0; host_rd = 0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(5.0 * 150000);
        n_cmp++; n_bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        for (int i = 0; i < 256; i++) begin val_b[i] = 0; val_s[i] = 0; end
        void'($urandom(32'd4711));
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R9: reset values of both indices
        op(2'd0, 0, 1, 8'h00);
        op(2'd2, 0, 1, 8'h00);
        op(2'd1, 0, 0, 8'h00);                 // R10 idle read data
        // R1: bit 7 of lower index ignored
        op(2'd0, 1, 0, 8'hFF);
        op(2'd0, 0, 1, 8'h00);
        // R2: upper index readback carries 128 offset
        op(2'd2, 1, 0, 8'h85);
        op(2'd2, 0, 1, 8'h00);
        // R3 and R8: storage at 20, repeated reads, index kept
        op(2'd0, 1, 0, 8'd20);
        op(2'd1, 1, 0, 8'h3C);
        op(2'd1, 0, 1, 8'h00);
        op(2'd1, 0, 1, 8'h00);
        op(2'd0, 0, 1, 8'h00);
        // R4: upper bank location 133, lower index untouched
        op(2'd2, 1, 0, 8'd5);
        op(2'd3, 1, 0, 8'h77);
        op(2'd3, 0, 1, 8'h00);
        op(2'd0, 0, 1, 8'h00);
        op(2'd1, 0, 1, 8'h00);
        // R5: clock register 10 forwarded
        op(2'd0, 1, 0, 8'h0A);
        op(2'd1, 1, 0, 8'h5A);
        op(2'd1, 0, 1, 8'h00);
        // R6: routed day location in large part, empty in small (R7)
        op(2'd0, 1, 0, 8'd125);
        op(2'd1, 1, 0, 8'h11);
        op(2'd1, 0, 1, 8'h00);
        // R6: small part routes 48, large part stores it
        op(2'd0, 1, 0, 8'd48);
        op(2'd1, 1, 0, 8'h22);
        op(2'd1, 0, 1, 8'h00);
        // R7: location 100 beyond small size, write ignored there
        op(2'd0, 1, 0, 8'd100);
        op(2'd1, 1, 0, 8'h99);
        op(2'd1, 0, 1, 8'h00);
        op(2'd3, 1, 0, 8'h44);
        op(2'd3, 0, 1, 8'h00);
        // random mix
        for (int i = 0; i < 1500; i++) begin
            logic [1:0] s;
            logic [7:0] d;
            bit w;
            s = 2'($urandom % 4);
            w = ($urandom % 2) == 0;
            d = 8'($urandom);
            if (!s[0] && w) d = {d[7], 2'b0, d[4:0]} + ((($urandom % 2) == 0) ? 8'd112 : 8'd0);
            op(s, w, !w, d);
        end
        idle();
        #1 chk("R10 final idle", b_rdata, 8'h00);
        finish_run();
    end

endmodule